// File: doc/BRIEF.md
# Graphics Port Request Enqueue Front-End

This block takes read and write requests from a graphics bus master and places them into an eight-entry request queue. A request reaches it by one of two addressing paths. In the strobe path, the master holds an active-low pipeline strobe low, and each rising edge takes the full 32-bit address from the shared address/data bus. In the sideband path, the master sends a command byte and then an address byte over a separate 8-bit bus. Capture on the sideband bus goes on alongside any traffic on the address/data bus.

After reset the block accepts no requests until a configuration write picks the mechanism. The first such write fixes the choice until the next reset. Any later write is dropped and sets a sticky error flag. A frame-based mode and a disabled mode are also available, and in both of them no requests are queued. Downstream logic drains the queue through a valid/pop interface. An enqueue that finds the queue full is dropped and sets a sticky overflow flag.

Top module: `gpReqFrontEnd`

## Requirements
- R1: While reset is asserted and right after it is released, qValid, modeLocked, cfgErr and ovfErr are 0 and modeOut is 0.
- R2: The first cfgWrEn pulse after reset sets modeLocked and copies cfgMode to modeOut from the next cycle on. The mode encodings are 2'b00 disabled, 2'b01 strobe, 2'b10 sideband and 2'b11 frame.
- R3: A cfgWrEn pulse while modeLocked is 1 leaves modeOut unchanged and sets cfgErr, which stays 1 until reset.
- R4: Before any configuration write, no level on pipeN or sbBus enqueues a request.
- R5: In strobe mode, every rising edge with pipeN low enqueues one entry with qAddr equal to adBus, qCmd 0 and qSideband 0.
- R6: In strobe mode, an edge with pipeN high enqueues nothing, and sbBus has no effect.
- R7: In sideband mode, a byte other than 8'hFF is taken as a command. The byte on the next cycle is taken as the address. One entry is then enqueued with qCmd equal to the command, qAddr equal to the zero-extended address byte and qSideband 1. An 8'hFF byte in the command position is idle and is never enqueued. pipeN and adBus have no effect in this mode.
- R8: In frame mode and in disabled mode, neither pipeN nor sbBus enqueues anything.
- R9: The queue holds up to 8 entries and returns them in arrival order. qValid is 1 while it is non-empty, and qPop with qValid removes the head at the clock edge.
- R10: An enqueue attempted while the queue is full and no pop occurs is dropped, the stored entries stay intact, and ovfErr becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Mode configuration write strobe |
| cfgMode | input | 2 | Mode value to write (00 off, 01 strobe, 10 sideband, 11 frame) |
| pipeN | input | 1 | Active-low pipelined address strobe |
| adBus | input | 32 | Shared address/data bus |
| sbBus | input | 8 | Sideband address/command bus |
| qPop | input | 1 | Remove queue head |
| qValid | output | 1 | Queue not empty |
| qAddr | output | 32 | Head entry address |
| qCmd | output | 8 | Head entry command byte (0 for strobe entries) |
| qSideband | output | 1 | Head entry came from the sideband path |
| modeLocked | output | 1 | Mode has been configured since reset |
| modeOut | output | 2 | Configured mode |
| cfgErr | output | 1 | Sticky: configuration write after lock |
| ovfErr | output | 1 | Sticky: enqueue dropped on full queue |

## Verification
The strobe path is driven with bursts of pipeN low separated by high gaps, while sbBus carries bytes that look like commands. The expected entry count and order show that only low-strobe edges enqueue and that the sideband bus is ignored. The sideband path gets command/address pairs mixed with all-ones idle bytes and an all-ones address byte, with pipeN held low throughout. This separates the idle-byte rule from the address-byte rule and shows that the strobe has no effect in this mode. Frame, disabled, unconfigured and relocked runs apply the same stimulus and expect either an empty queue or the original mode. An overflow run pushes nine addresses and drains eight to show that the ninth is dropped and the stored order is kept.

// File: rtl/gpReqPkg.sv
package gpReqPkg;
  localparam int ADDR_W = 32;
  localparam int SB_W   = 8;
  localparam logic [SB_W-1:0] SB_IDLE = '1;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_STROBE   = 2'b01,
    MODE_SIDEBAND = 2'b10,
    MODE_FRAME    = 2'b11
  } enqMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pushSb;
    logic latchCmd;
    logic pop;
  } qCtrl_t;

  typedef struct packed {
    logic              sb;
    logic [SB_W-1:0]   cmd;
    logic [ADDR_W-1:0] addr;
  } qEntry_t;
endpackage

// File: rtl/gpReqCtrl.sv
module gpReqCtrl
  import gpReqPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrEn,
  input  logic [1:0]      cfgMode,
  input  logic            pipeN,
  input  logic [SB_W-1:0] sbBus,
  input  logic            qPop,
  input  logic            qFull,
  input  logic            qEmpty,
  output qCtrl_t          ctrl,
  output enqMode_t        modeQ,
  output logic            locked,
  output logic            cfgErr,
  output logic            ovfErr
);
  logic sbHalf;      // command byte held, address byte expected next
  logic strobeMode;
  logic sbMode;
  logic strobeReq;
  logic sbReq;
  logic wantPush;
  logic popOk;

  assign strobeMode = locked && (modeQ == MODE_STROBE);
  assign sbMode     = locked && (modeQ == MODE_SIDEBAND);
  assign strobeReq  = strobeMode && !pipeN;
  assign sbReq      = sbMode && sbHalf;
  assign wantPush   = strobeReq || sbReq;
  assign popOk      = qPop && !qEmpty;

  always_comb begin
    ctrl.pop      = popOk;
    ctrl.push     = wantPush && (!qFull || popOk);
    ctrl.pushSb   = sbReq;
    ctrl.latchCmd = sbMode && !sbHalf && (sbBus != SB_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b0;
      modeQ  <= MODE_OFF;
      cfgErr <= 1'b0;
      ovfErr <= 1'b0;
      sbHalf <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        if (!locked) begin
          locked <= 1'b1;
          modeQ  <= enqMode_t'(cfgMode);
        end else begin
          cfgErr <= 1'b1;
        end
      end
      if (wantPush && qFull && !popOk) ovfErr <= 1'b1;
      if (sbMode) begin
        if (sbHalf)                     sbHalf <= 1'b0;
        else if (sbBus != SB_IDLE)      sbHalf <= 1'b1;
      end else begin
        sbHalf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpReqQueue.sv
module gpReqQueue
  import gpReqPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  qCtrl_t            ctrl,
  input  logic [ADDR_W-1:0] adBus,
  input  logic [SB_W-1:0]   sbBus,
  output qEntry_t           head,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  qEntry_t          mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [SB_W-1:0]  cmdHold;
  qEntry_t          newEntry;

  always_comb begin
    if (ctrl.pushSb) begin
      newEntry.sb   = 1'b1;
      newEntry.cmd  = cmdHold;
      newEntry.addr = {{(ADDR_W-SB_W){1'b0}}, sbBus};
    end else begin
      newEntry.sb   = 1'b0;
      newEntry.cmd  = '0;
      newEntry.addr = adBus;
    end
  end

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign head  = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      cmdHold <= '0;
    end else begin
      if (ctrl.latchCmd) cmdHold <= sbBus;
      if (ctrl.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (ctrl.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({ctrl.push, ctrl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // storage, one register per slot
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ctrl.push && (wrPtr == PTR_W'(gi))) mem[gi] <= newEntry;
    end
  end
endmodule

// File: rtl/gpReqFrontEnd.sv
module gpReqFrontEnd
  import gpReqPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [1:0]  cfgMode,
  input  logic        pipeN,
  input  logic [31:0] adBus,
  input  logic [7:0]  sbBus,
  input  logic        qPop,
  output logic        qValid,
  output logic [31:0] qAddr,
  output logic [7:0]  qCmd,
  output logic        qSideband,
  output logic        modeLocked,
  output logic [1:0]  modeOut,
  output logic        cfgErr,
  output logic        ovfErr
);
  qCtrl_t           ctrl;
  enqMode_t         modeQ;
  qEntry_t          head;
  logic             qFull;
  logic             qEmpty;
  logic [CNT_W-1:0] qCount;

  gpReqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .pipeN(pipeN), .sbBus(sbBus), .qPop(qPop), .qFull(qFull),
    .qEmpty(qEmpty), .ctrl(ctrl), .modeQ(modeQ), .locked(modeLocked),
    .cfgErr(cfgErr), .ovfErr(ovfErr)
  );

  gpReqQueue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .adBus(adBus), .sbBus(sbBus),
    .head(head), .full(qFull), .empty(qEmpty), .count(qCount)
  );

  assign qValid    = !qEmpty;
  assign qAddr     = head.addr;
  assign qCmd      = head.cmd;
  assign qSideband = head.sb;
  assign modeOut   = modeQ;
endmodule

// File: rtl/gpReqFrontEndChk.sv
module gpReqFrontEndChk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic             pipeN,
  input logic             qPop,
  input logic             qValid,
  input logic             modeLocked,
  input logic [1:0]       modeOut,
  input logic             cfgErr,
  input logic             ovfErr,
  input logic [CNT_W-1:0] qCount
);
  // R3: mode holds once locked
  p_mode_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    modeLocked |=> (modeLocked && $stable(modeOut)));
  // R3: write after lock raises sticky flag
  p_relock_err_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeLocked && cfgWrEn) |=> cfgErr);
  p_cfgerr_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);
  // R10: overflow flag sticky
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr);
  // R9: occupancy bound
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(DEPTH));
  // R4: unconfigured block never grows the queue
  p_unconf_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !modeLocked |=> (qCount <= $past(qCount)));
  // R8: frame and disabled modes never grow the queue
  p_quiet_modes_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeLocked && (modeOut == 2'b11 || modeOut == 2'b00)) |=> (qCount <= $past(qCount)));
  // R5: strobe low with room and no pop adds exactly one entry
  p_strobe_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeLocked && modeOut == 2'b01 && !pipeN && qCount < CNT_W'(DEPTH) && !(qPop && qValid))
      |=> (qCount == $past(qCount) + 1'b1));
  // R6: strobe high in strobe mode adds nothing
  p_strobe_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeLocked && modeOut == 2'b01 && pipeN) |=> (qCount <= $past(qCount)));
endmodule

bind gpReqFrontEnd gpReqFrontEndChk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .pipeN(pipeN), .qPop(qPop),
  .qValid(qValid), .modeLocked(modeLocked), .modeOut(modeOut),
  .cfgErr(cfgErr), .ovfErr(ovfErr), .qCount(qCount)
);

// File: tb/test_gpReqFrontEnd.sv
module test_gpReqFrontEnd;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgMode = 2'b00;
  logic        pipeN = 1'b1;
  logic [31:0] adBus = '0;
  logic [7:0]  sbBus = 8'hFF;
  logic        qPop = 1'b0;
  logic        qValid, qSideband, modeLocked, cfgErr, ovfErr;
  logic [31:0] qAddr;
  logic [7:0]  qCmd;
  logic [1:0]  modeOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  gpReqFrontEnd i_gpReqFrontEnd (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .pipeN(pipeN), .adBus(adBus), .sbBus(sbBus), .qPop(qPop),
    .qValid(qValid), .qAddr(qAddr), .qCmd(qCmd), .qSideband(qSideband),
    .modeLocked(modeLocked), .modeOut(modeOut), .cfgErr(cfgErr), .ovfErr(ovfErr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idleIn();
    pipeN = 1'b1; sbBus = 8'hFF; adBus = '0; qPop = 1'b0; cfgWrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    idleIn();
    rstN = 1'b0;
    @(negedge clk);
    chk(!qValid && !modeLocked && !cfgErr && !ovfErr && modeOut == 2'b00,
        "R1 outputs in reset", {qValid, modeLocked, cfgErr, ovfErr, modeOut}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!qValid && !modeLocked && !cfgErr && !ovfErr && modeOut == 2'b00,
        "R1 outputs after reset", {qValid, modeLocked, cfgErr, ovfErr, modeOut}, 0);
  endtask

  task automatic cfgWrite(input logic [1:0] m);
    cfgWrEn = 1'b1; cfgMode = m;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic popExpect(input logic [31:0] a, input logic [7:0] c, input logic sb, input string tag);
    chk(qValid, tag, {63'b0, qValid}, 1);
    chk(qAddr == a && qCmd == c && qSideband == sb, tag, {qSideband, qCmd, qAddr}, {sb, c, a});
    qPop = 1'b1;
    @(negedge clk);
    qPop = 1'b0;
  endtask

  task automatic tUnconfigured();
    doReset();
    for (int i = 0; i < 4; i++) begin
      pipeN = 1'b0; adBus = 32'h1000 + i; sbBus = 8'h20 + 8'(i);
      @(negedge clk);
    end
    idleIn();
    @(negedge clk);
    chk(!qValid, "R4 no enqueue before configuration", {63'b0, qValid}, 0);
  endtask

  task automatic tStrobe();
    doReset();
    cfgWrite(2'b01);
    chk(modeLocked && modeOut == 2'b01, "R2 strobe mode locked", {modeLocked, modeOut}, {1'b1, 2'b01});
    for (int i = 0; i < 3; i++) begin
      pipeN = 1'b0; adBus = 32'hA000_0000 + i; sbBus = 8'h11;
      @(negedge clk);
    end
    for (int i = 0; i < 2; i++) begin
      pipeN = 1'b1; adBus = 32'hDEAD_0000 + i; sbBus = 8'h33;
      @(negedge clk);
    end
    pipeN = 1'b0; adBus = 32'hB000_0007; sbBus = 8'hFF;
    @(negedge clk);
    idleIn();
    for (int i = 0; i < 3; i++) popExpect(32'hA000_0000 + i, 8'h00, 1'b0, "R5 strobe entry");
    popExpect(32'hB000_0007, 8'h00, 1'b0, "R9 order after gap");
    chk(!qValid, "R6 gap and sideband bytes add nothing", {63'b0, qValid}, 0);
  endtask

  task automatic tSideband();
    doReset();
    cfgWrite(2'b10);
    chk(modeLocked && modeOut == 2'b10, "R2 sideband mode locked", {modeLocked, modeOut}, {1'b1, 2'b10});
    pipeN = 1'b0; adBus = 32'h5555_0000;
    sbBus = 8'h5A; @(negedge clk);
    sbBus = 8'h34; @(negedge clk);
    sbBus = 8'hFF; @(negedge clk);
    sbBus = 8'hFF; @(negedge clk);
    sbBus = 8'h81; @(negedge clk);
    sbBus = 8'hFF; @(negedge clk);
    sbBus = 8'hFF; @(negedge clk);
    idleIn();
    popExpect(32'h0000_0034, 8'h5A, 1'b1, "R7 first sideband pair");
    popExpect(32'h0000_00FF, 8'h81, 1'b1, "R7 all-ones address byte");
    chk(!qValid, "R7 idle bytes and strobe add nothing", {63'b0, qValid}, 0);
  endtask

  task automatic tQuietMode(input logic [1:0] m, input string tag);
    doReset();
    cfgWrite(m);
    chk(modeLocked && modeOut == m, tag, {modeLocked, modeOut}, {1'b1, m});
    for (int i = 0; i < 4; i++) begin
      pipeN = 1'b0; adBus = 32'h7700 + i; sbBus = 8'h40 + 8'(i);
      @(negedge clk);
    end
    idleIn();
    @(negedge clk);
    chk(!qValid, tag, {63'b0, qValid}, 0);
  endtask

  task automatic tRelock();
    doReset();
    cfgWrite(2'b01);
    cfgWrite(2'b10);
    chk(cfgErr, "R3 cfgErr set on second write", {63'b0, cfgErr}, 1);
    chk(modeOut == 2'b01, "R3 mode unchanged", {62'b0, modeOut}, 2'b01);
    pipeN = 1'b0; adBus = 32'hC0DE_0001;
    @(negedge clk);
    idleIn();
    @(negedge clk);
    chk(cfgErr, "R3 cfgErr sticky", {63'b0, cfgErr}, 1);
    popExpect(32'hC0DE_0001, 8'h00, 1'b0, "R3 strobe path still active");
  endtask

  task automatic tOverflow();
    doReset();
    cfgWrite(2'b01);
    for (int i = 0; i < 9; i++) begin
      pipeN = 1'b0; adBus = 32'hF000_0000 + i;
      @(negedge clk);
    end
    idleIn();
    @(negedge clk);
    chk(ovfErr, "R10 overflow flag", {63'b0, ovfErr}, 1);
    for (int i = 0; i < 8; i++) popExpect(32'hF000_0000 + i, 8'h00, 1'b0, "R9 full queue order");
    chk(!qValid, "R10 ninth entry dropped", {63'b0, qValid}, 0);
    chk(ovfErr, "R10 overflow sticky", {63'b0, ovfErr}, 1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    tUnconfigured();
    tStrobe();
    tSideband();
    tQuietMode(2'b11, "R8 frame mode quiet");
    tQuietMode(2'b00, "R8 disabled mode quiet");
    tRelock();
    tOverflow();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end
endmodule